// File: doc/BRIEF.md
# I2C Register Target with Pointer Stepping

This block is a byte-wide register target for a two-wire serial bus. It watches open-drain clock and data lines on its own system clock, recognises START, repeated START and STOP, and responds only to its own 7-bit device address. After the address, the master's first byte is a register pointer. Any bytes that follow in a write land in a 128-entry bank of 8-bit registers. For a read, the master turns the bus around with a repeated START and the address with the read bit set. The target then shifts out register contents until the master declines a byte.

The top bit of the pointer byte chooses the addressing mode. When it is set, the pointer steps after every data byte and wraps from 127 back to 0. When it is clear, every byte goes to or comes from the same register. A side-band busy input lets the surrounding logic refuse new transactions, which it does by declining the address. During a transaction the same input stretches the clock at byte boundaries. A parallel host port gives the rest of the chip direct access to the bank.

Top module: `i2c_regslave`

## Requirements
- R1: A byte after START whose upper seven bits equal the device address (default 7'h3A; bit 0 = 1 means read) is acknowledged by pulling SDA low during the ninth clock.
- R2: In a write, the byte after the address sets the pointer from its bits 6:0. Each later byte, received MSB first, is stored at the pointer. Every such byte is acknowledged.
- R3: When bit 7 of the pointer byte is 1, the pointer advances by one after each data byte, written or read, and wraps from 7'h7F to 7'h00.
- R4: When bit 7 of the pointer byte is 0, the pointer does not move, so consecutive bytes use one register.
- R5: After a repeated START and the address with bit 0 = 1, the target drives register bytes MSB first. It starts pulling SDA low only while SCL is low.
- R6: When the master leaves SDA high in the acknowledge slot of a read byte, the target releases SDA and drives nothing more until the next START.
- R7: A STOP (SDA rising while SCL high) returns the target to idle. Clock pulses that follow without a START are not acknowledged.
- R8: If `dev_busy` is high when a matching address byte completes, the address is not acknowledged.
- R9: If `dev_busy` is high when a pointer, write or read byte completes, the target holds SCL low. It releases SCL within two system clocks after `dev_busy` falls.
- R10: Reset clears every register to 8'h00. The host port writes a register on `host_we` and reads any register combinationally.
- R11: After an address that does not match, the target neither acknowledges nor stores any byte until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_busy | input | 1 | Refuse address / stretch clock while high |
| host_we | input | 1 | Host port write strobe |
| host_addr | input | 7 | Host port register index |
| host_wdata | input | 8 | Host port write data |
| host_rdata | output | 8 | Host port read data at `host_addr` |

## Verification
The assertions assume a bus master that changes SDA only while SCL is low, except to form START and STOP. They also assume that SCL stays low for several system clocks after each falling edge, so the target's registered reaction lands while the line is still low. The bench master holds every SCL phase for ten or twenty system clocks. It changes SDA a quarter period after each falling edge and waits for the sensed SCL to actually rise before it times the high phase, so it respects clock stretching. `dev_busy` is changed only while the master is between bits with SCL low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int PTR_W = 7;
  localparam int DAT_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WR,
    ST_RD,
    ST_IGN
  } st_e;

  // Pointer after one data byte: step with wrap, or stay.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p, input logic inc);
    return inc ? p + PTR_W'(1) : p;
  endfunction

  // Does a received address byte select this device?
  function automatic logic addr_hit(input logic [DAT_W-1:0] b, input logic [PTR_W-1:0] dev);
    return b[DAT_W-1:1] == dev;
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (bus_we) begin
      mem[bus_addr] <= bus_wdata;
    end else if (host_we) begin
      mem[host_addr] <= host_wdata;
    end
  end

  assign bus_rdata  = mem[bus_addr];
  assign host_rdata = mem[host_addr];

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [PTR_W-1:0] DEV_ADDR = 7'h3A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             dev_busy,
  output logic             bus_we,
  output logic [PTR_W-1:0] bus_addr,
  output logic [DAT_W-1:0] bus_wdata,
  input  logic [DAT_W-1:0] bus_rdata,
  output logic             sda_oe,
  output logic             scl_oe
);
  localparam logic [3:0] BITS = 4'(DAT_W);

  st_e              st;
  logic [3:0]       bitcnt;
  logic             ackph;
  logic [DAT_W-1:0] rx_sh, tx_sh;
  logic [PTR_W-1:0] ptr;
  logic             inc, is_read, ack_drv, hold;

  // Named internal events
  logic active, ev_bit_in, ev_tx_shift, ev_byte_done, ev_ack_rise, ev_ack_end;
  assign active       = (st == ST_ADDR) || (st == ST_SUB) || (st == ST_WR) || (st == ST_RD);
  assign ev_bit_in    = active && scl_rise && !ackph && (bitcnt < BITS);
  assign ev_tx_shift  = active && scl_fall && !ackph && (st == ST_RD) && (bitcnt != 4'd0) && (bitcnt < BITS);
  assign ev_byte_done = active && scl_fall && !ackph && (bitcnt == BITS);
  assign ev_ack_rise  = active && scl_rise && ackph;
  assign ev_ack_end   = active && scl_fall && ackph;

  assign bus_we    = ev_byte_done && (st == ST_WR);
  assign bus_addr  = ptr;
  assign bus_wdata = rx_sh;
  assign sda_oe    = ack_drv || ((st == ST_RD) && !ackph && !tx_sh[DAT_W-1]);
  assign scl_oe    = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      ackph   <= 1'b0;
      rx_sh   <= '0;
      tx_sh   <= '1;
      ptr     <= '0;
      inc     <= 1'b0;
      is_read <= 1'b0;
      ack_drv <= 1'b0;
      hold    <= 1'b0;
    end else if (start_det || stop_det) begin
      st      <= start_det ? ST_ADDR : ST_IDLE;
      bitcnt  <= '0;
      ackph   <= 1'b0;
      ack_drv <= 1'b0;
      hold    <= 1'b0;
    end else begin
      if (!dev_busy) hold <= 1'b0;
      if (ev_bit_in) begin
        rx_sh  <= {rx_sh[DAT_W-2:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end else if (ev_tx_shift) begin
        tx_sh <= {tx_sh[DAT_W-2:0], 1'b1};
      end else if (ev_byte_done) begin
        ackph <= 1'b1;
        unique case (st)
          ST_ADDR: begin
            if (addr_hit(rx_sh, DEV_ADDR) && !dev_busy) begin
              ack_drv <= 1'b1;
              is_read <= rx_sh[0];
            end else begin
              st <= ST_IGN;
            end
          end
          ST_SUB: begin
            ptr     <= rx_sh[PTR_W-1:0];
            inc     <= rx_sh[DAT_W-1];
            ack_drv <= 1'b1;
            hold    <= dev_busy;
          end
          ST_WR: begin
            ptr     <= ptr_step(ptr, inc);
            ack_drv <= 1'b1;
            hold    <= dev_busy;
          end
          default: hold <= dev_busy;
        endcase
      end else if (ev_ack_rise) begin
        if (st == ST_ADDR && is_read) begin
          tx_sh <= bus_rdata;
          ptr   <= ptr_step(ptr, inc);
        end else if (st == ST_RD) begin
          if (!sda_s) begin
            tx_sh <= bus_rdata;
            ptr   <= ptr_step(ptr, inc);
          end else begin
            st <= ST_IGN;
          end
        end
      end else if (ev_ack_end) begin
        ackph   <= 1'b0;
        bitcnt  <= '0;
        ack_drv <= 1'b0;
        if (st == ST_ADDR)     st <= is_read ? ST_RD : ST_SUB;
        else if (st == ST_SUB) st <= ST_WR;
      end
    end
  end

  // R5: SDA is pulled low only while SCL is low
  a_r5_sda_low_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R8: busy at address completion means no acknowledge
  a_r8_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte_done && st == ST_ADDR && dev_busy) |=> !sda_oe);

  // R9: stretch lifts once busy is low
  a_r9_stretch_release: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_busy |=> !scl_oe);

  // R11, R6: ignoring state never drives the bus
  a_r11_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> (!sda_oe && !scl_oe));

  // R4: fixed pointer after a write
  a_r4_fixed_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !inc) |=> $stable(ptr));

  // R3: wrap from top register to zero
  a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && inc && ptr == '1) |=> (ptr == '0));

  // R7: STOP returns to idle
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE));

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2cs_pkg::*;
#(
  parameter logic [PTR_W-1:0] DEV_ADDR    = 7'h3A,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             dev_busy,
  input  logic             host_we,
  input  logic [PTR_W-1:0] host_addr,
  input  logic [DAT_W-1:0] host_wdata,
  output logic [DAT_W-1:0] host_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             bus_we;
  logic [PTR_W-1:0] bus_addr;
  logic [DAT_W-1:0] bus_wdata, bus_rdata;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .dev_busy(dev_busy),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sda_oe(sda_oe), .scl_oe(scl_oe)
  );

  i2cs_regs #(.AW(PTR_W), .DW(DAT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

endmodule

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h3A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic dev_busy = 1'b0, host_we = 1'b0;
  logic [6:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic scl_oe, sda_oe, scl_bus, sda_bus;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign scl_bus = ~(m_scl_low | scl_oe);
  assign sda_bus = ~(m_sda_low | sda_oe);

  i2c_regslave #(.DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .dev_busy(dev_busy),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  function automatic logic [6:0] model_step(logic [6:0] p, logic inc);
    return inc ? ((p == 7'd127) ? 7'd0 : p + 7'd1) : p;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wclk(int n); repeat (n) @(negedge clk); endtask

  task automatic scl_release();
    m_scl_low = 1'b0;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    m_sda_low = !b; wclk(Q); scl_release(); wclk(2*Q); m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda_low = 1'b0; wclk(Q); scl_release(); wclk(Q); b = sda_bus; wclk(Q); m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic do_start();
    m_sda_low = 1'b1; wclk(2*Q); m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic do_rstart();
    m_sda_low = 1'b0; wclk(Q); scl_release(); wclk(2*Q); m_sda_low = 1'b1; wclk(2*Q); m_scl_low = 1'b1; wclk(Q);
  endtask

  task automatic do_stop();
    m_sda_low = 1'b1; wclk(Q); scl_release(); wclk(2*Q); m_sda_low = 1'b0; wclk(2*Q);
  endtask

  task automatic send_bits(logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack_n);
    send_bits(b); bit_in(ack_n);
  endtask

  task automatic recv_byte(logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(nack);
  endtask

  task automatic host_rd(logic [6:0] a, output logic [7:0] d);
    host_addr = a; wclk(1); d = host_rdata;
  endtask

  task automatic host_wr(logic [6:0] a, logic [7:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1; wclk(1); host_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 sda idle", sda_oe, 0);
    check("R10 scl idle", scl_oe, 0);
    host_rd(7'h05, d); check("R10 reset reg", d, 8'h00);
    host_wr(7'h03, 8'hA5); host_rd(7'h03, d); check("R10 host write", d, 8'hA5);
  endtask

  task automatic t_write_inc();
    logic a; logic [7:0] d;
    do_start();
    send_byte({DEV, 1'b0}, a); check("R1 addr ack", a, 0);
    send_byte(8'h90, a); check("R2 sub ack", a, 0);
    send_byte(8'h11, a); check("R2 data ack", a, 0);
    send_byte(8'h22, a); send_byte(8'h33, a);
    do_stop();
    host_rd(7'h10, d); check("R2 reg10", d, 8'h11);
    host_rd(model_step(7'h10, 1'b1), d); check("R3 reg11", d, 8'h22);
    host_rd(7'h12, d); check("R3 reg12", d, 8'h33);
  endtask

  task automatic t_read_inc();
    logic a, b; logic [7:0] d;
    do_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h90, a);
    do_rstart();
    send_byte({DEV, 1'b1}, a); check("R1 read addr ack", a, 0);
    recv_byte(1'b0, d); check("R5 read byte0", d, 8'h11);
    recv_byte(1'b0, d); check("R3 read byte1", d, 8'h22);
    recv_byte(1'b1, d); check("R5 read byte2", d, 8'h33);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    check("R6 released after nack", d, 8'hFF);
    bit_in(b);
    do_stop();
  endtask

  task automatic t_fixed();
    logic a; logic [7:0] d;
    do_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h20, a);
    send_byte(8'h44, a); send_byte(8'h55, a); check("R4 second ack", a, 0);
    do_stop();
    host_rd(7'h20, d); check("R4 same reg", d, 8'h55);
    host_rd(7'h21, d); check("R4 neighbour", d, 8'h00);
    do_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h20, a);
    do_rstart();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d); check("R4 read 1", d, 8'h55);
    recv_byte(1'b1, d); check("R4 read 2", d, 8'h55);
    do_stop();
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    do_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'hFF, a);
    send_byte(8'h66, a); send_byte(8'h77, a);
    do_stop();
    host_rd(7'h7F, d); check("R3 top reg", d, 8'h66);
    host_rd(model_step(7'h7F, 1'b1), d); check("R3 wrapped reg", d, 8'h77);
  endtask

  task automatic t_other_addr();
    logic a; logic [7:0] d;
    do_start();
    send_byte({7'h22, 1'b0}, a); check("R11 foreign nack", a, 1);
    send_byte(8'h00, a); check("R11 sub ignored", a, 1);
    send_byte(8'hEE, a); check("R11 data ignored", a, 1);
    do_stop();
    host_rd(7'h00, d); check("R11 reg kept", d, 8'h77);
  endtask

  task automatic t_busy_addr();
    logic a;
    dev_busy = 1'b1;
    do_start();
    send_byte({DEV, 1'b0}, a); check("R8 busy nack", a, 1);
    do_stop();
    dev_busy = 1'b0;
  endtask

  task automatic t_stretch();
    logic a; logic [7:0] d;
    do_start();
    send_byte({DEV, 1'b0}, a);
    dev_busy = 1'b1;
    send_bits(8'h05);
    m_sda_low = 1'b0; wclk(Q);
    check("R9 stretch on", scl_oe, 1);
    m_scl_low = 1'b0; wclk(50);
    check("R9 scl held", scl_bus, 0);
    dev_busy = 1'b0; wclk(4);
    check("R9 scl freed", scl_bus, 1);
    wclk(Q); check("R9 ack after stretch", sda_bus, 0);
    wclk(Q); m_scl_low = 1'b1; wclk(Q);
    send_byte(8'h9A, a);
    do_stop();
    host_rd(7'h05, d); check("R9 data stored", d, 8'h9A);
  endtask

  task automatic t_no_start();
    logic a;
    do_start(); send_byte({DEV, 1'b0}, a); do_stop();
    m_scl_low = 1'b1; wclk(Q);
    send_byte({DEV, 1'b0}, a); check("R7 no ack w/o start", a, 1);
    do_stop();
  endtask

  initial begin
    wclk(5); rst_n = 1'b1; wclk(5);
    t_reset();
    t_write_inc();
    t_read_inc();
    t_fixed();
    t_wrap();
    t_other_addr();
    t_busy_addr();
    t_stretch();
    t_no_start();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule